// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Generator

This block sits on the host side of an external asynchronous static RAM and turns single read or write requests into properly timed bus cycles on the chip-enable, write-enable and output-enable strobes (all active low), a 13-bit address bus and an 8-bit data bus. Every interval is a parameter counted in clock ticks, so one netlist serves any speed grade by choosing tick counts that cover the memory's minimum nanosecond figures at the chosen clock. The defaults suit a 70 ns part at 125 MHz (8 ns per tick).

A request is handed over on a valid/ready pair. A transfer happens on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in flight, so back-pressure lasts for the whole access, and a request offered while busy is simply not taken. Each access ends with a one-cycle `rsp_valid` pulse. The response side has no back-pressure: `rsp_rdata` stays put until the next read finishes. Each write picks its own termination style with `req_ce_term`. With the low setting, write-enable bounds the write pulse and rises first. With the high setting, chip-enable bounds the pulse and rises first.

The data bus is modelled as separate out and in vectors plus an output-enable. Output-enable stays high on every write, so the host never fights the memory's output drivers.

Top module: `sram_cycle_gen`

## Requirements
- R1: After reset, and whenever idle, chip-enable, write-enable and output-enable are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read holds chip-enable and output-enable low and write-enable high for exactly T_RD cycles (default 9), starting the cycle after the accepting edge.
- R3: At the end of a read, `rsp_valid` is high for exactly one cycle, and `rsp_rdata` holds the value `mem_dq_i` had in the last cycle of the read interval.
- R4: A write with `req_ce_term` = 0 drops chip-enable first for T_AS cycles (default 1) with write-enable high. It then holds both low for T_WP cycles (default 7). Write-enable then rises while chip-enable stays low for T_WR_WE cycles (default 1).
- R5: A write with `req_ce_term` = 1 drops write-enable first for T_AS cycles with chip-enable high. It then holds both low for T_WP cycles. Chip-enable then rises while write-enable stays low for T_WR_CE cycles (default 2).
- R6: Output-enable is high in every cycle in which write-enable is low.
- R7: During a write, `mem_dq_oe` is high and `mem_dq_o` equals the request's data from the first strobe cycle until both strobes are high again. `mem_dq_oe` is never high while output-enable is low.
- R8: `mem_addr` takes the request address at the accepting edge and holds it without change until `req_ready` is high again.
- R9: A write occupies max(T_WC, T_AS+T_WP+recovery) cycles from acceptance to `rsp_valid`, with padding cycles that have all strobes high. With the defaults this is 9 cycles for the write-enable style and 10 for the chip-enable style. A read occupies T_RD cycles.
- R10: While an access is in flight, `req_ready` is low and a `req_valid` pulse starts no access and produces no response.
- R11: `req_ready` is high in the cycle `rsp_valid` is high, so a new request can be taken on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block idle; request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ce_term | input | 1 | Write termination: 0 write-enable bounds, 1 chip-enable bounds |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data from the last read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 13 | Address to memory |
| mem_dq_o | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 8 | Data returned by memory |

## Verification
The bench runs a table of writes and reads against a small behavioural memory. The memory stores a byte only at the rising edge that ends the overlap of chip-enable and write-enable. Because of this, a read-back mismatch shows a write that ended at the wrong edge or dropped its data too early, while the recorded strobe trace separates the two termination styles by which strobe falls first and which rises first. Addresses with differing upper bits show whether the full address reaches the bus. An overwrite followed by a read of a never-written location shows that data is taken from the bus and not held over from an earlier read. Directed tests cover the idle state after reset and a request offered in the middle of a write, which must start nothing.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_RECOV = 3'd3,
    PH_TAIL  = 3'd4,
    PH_READ  = 3'd5
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // padding needed to stretch a sequence of length 'used' up to 'total'
  function automatic int unsigned pad_to(input int unsigned total, input int unsigned used);
    return (total > used) ? (total - used) : 0;
  endfunction

endpackage

// File: rtl/sram_tick_timer.sv
module sram_tick_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

  // a loaded interval counts down one per tick and never skips
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_cyc_pkg::*;
#(
  parameter int unsigned T_AS    = 1,
  parameter int unsigned T_WP    = 7,
  parameter int unsigned T_WR_WE = 1,
  parameter int unsigned T_WR_CE = 2,
  parameter int unsigned T_WC    = 9,
  parameter int unsigned T_RD    = 9,
  parameter int unsigned CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          acc_write,
  input  logic          acc_ce_term,
  input  logic          last,
  output phase_e        phase_q,
  output phase_e        phase_d,
  output logic          style_q,
  output logic          style_d,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          done
);

  localparam int unsigned L_AS   = max2(T_AS, 1);
  localparam int unsigned L_WP   = max2(T_WP, 1);
  localparam int unsigned L_RWE  = max2(T_WR_WE, 1);
  localparam int unsigned L_RCE  = max2(T_WR_CE, 1);
  localparam int unsigned L_RD   = max2(T_RD, 1);
  localparam int unsigned PAD_WE = pad_to(T_WC, L_AS + L_WP + L_RWE);
  localparam int unsigned PAD_CE = pad_to(T_WC, L_AS + L_WP + L_RCE);

  function automatic int unsigned len_of(input phase_e p, input logic ce_term);
    case (p)
      PH_SETUP: return L_AS;
      PH_PULSE: return L_WP;
      PH_RECOV: return ce_term ? L_RCE : L_RWE;
      PH_TAIL:  return ce_term ? max2(PAD_CE, 1) : max2(PAD_WE, 1);
      PH_READ:  return L_RD;
      default:  return 1;
    endcase
  endfunction

  logic pad_needed;
  assign pad_needed = style_q ? (PAD_CE != 0) : (PAD_WE != 0);

  always_comb begin
    phase_d = phase_q;
    style_d = style_q;
    case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = acc_write ? PH_SETUP : PH_READ;
        style_d = acc_ce_term;
      end
      PH_SETUP: if (last) phase_d = PH_PULSE;
      PH_PULSE: if (last) phase_d = PH_RECOV;
      PH_RECOV: if (last) phase_d = pad_needed ? PH_TAIL : PH_IDLE;
      PH_TAIL:  if (last) phase_d = PH_IDLE;
      PH_READ:  if (last) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  assign load     = (phase_d != phase_q) && (phase_d != PH_IDLE);
  assign load_val = CW'(len_of(phase_d, style_d) - 1);
  assign done     = (phase_q != PH_IDLE) && (phase_d == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      style_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      style_q <= style_d;
    end
  end

  // the termination style chosen at acceptance holds for the whole write
  AST_STYLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_d != PH_IDLE) |=> $stable(style_q)); // R5

endmodule

// File: rtl/sram_strobe_map.sv
module sram_strobe_map
  import sram_cyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_d,
  input  logic   style_d,
  output logic   ce_n,
  output logic   we_n,
  output logic   oe_n,
  output logic   dq_oe
);

  logic ce_d, we_d, oe_d, drv_d;

  always_comb begin
    ce_d  = 1'b1;
    we_d  = 1'b1;
    oe_d  = 1'b1;
    drv_d = 1'b0;
    case (phase_d)
      PH_READ: begin
        ce_d = 1'b0;
        oe_d = 1'b0;
      end
      PH_SETUP, PH_RECOV: begin
        ce_d  = style_d;
        we_d  = !style_d;
        drv_d = 1'b1;
      end
      PH_PULSE: begin
        ce_d  = 1'b0;
        we_d  = 1'b0;
        drv_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= ce_d;
      we_n  <= we_d;
      oe_n  <= oe_d;
      dq_oe <= drv_d;
    end
  end

  AST_OE_HIGH_WHILE_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R6

  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R7

  // data stays driven while the overlap closes
  AST_DRIVE_ACROSS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> dq_oe); // R7

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sram_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned T_AS    = 1,
  parameter int unsigned T_WP    = 7,
  parameter int unsigned T_WR_WE = 1,
  parameter int unsigned T_WR_CE = 2,
  parameter int unsigned T_WC    = 9,
  parameter int unsigned T_RD    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ce_term,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned LMAX = max2(max2(max2(T_AS, T_WP), max2(T_WR_WE, T_WR_CE)),
                                      max2(max2(T_WC, T_RD), 1));
  localparam int unsigned CW   = $clog2(LMAX + 1);

  phase_e          phase_q, phase_d;
  logic            style_q, style_d;
  logic            load, last, done, accept;
  logic [CW-1:0]   load_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic            rsp_q;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  sram_phase_fsm #(
    .T_AS(T_AS), .T_WP(T_WP), .T_WR_WE(T_WR_WE), .T_WR_CE(T_WR_CE),
    .T_WC(T_WC), .T_RD(T_RD), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .acc_write(req_write),
    .acc_ce_term(req_ce_term), .last(last), .phase_q(phase_q), .phase_d(phase_d),
    .style_q(style_q), .style_d(style_d), .load(load), .load_val(load_val), .done(done)
  );

  sram_tick_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  sram_strobe_map u_map (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .style_d(style_d),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_q <= done;
      if (done && phase_q == PH_READ) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mem_addr)); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R11

  AST_BUSY_NO_STROBE_CHANGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> (mem_ce_n && mem_we_n && mem_oe_n)); // R10

endmodule

// File: tb/sram_cycle_gen_tb.sv
module sram_cycle_gen_tb;

  localparam int TB_AS = 1, TB_WP = 7, TB_RWE = 1, TB_RCE = 2, TB_WC = 9, TB_RD = 9;
  localparam int LEN_WWE = (TB_WC > TB_AS + TB_WP + TB_RWE) ? TB_WC : TB_AS + TB_WP + TB_RWE;
  localparam int LEN_WCE = (TB_WC > TB_AS + TB_WP + TB_RCE) ? TB_WC : TB_AS + TB_WP + TB_RCE;

  typedef struct packed {
    logic        wr;
    logic        ce_term;
    logic [12:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 13'h0003, 8'hA5},
    '{1'b1, 1'b1, 13'h1FF7, 8'h3C},
    '{1'b0, 1'b0, 13'h0003, 8'hA5},
    '{1'b0, 1'b0, 13'h1FF7, 8'h3C},
    '{1'b1, 1'b1, 13'h0003, 8'h5A},
    '{1'b0, 1'b0, 13'h0003, 8'h5A},
    '{1'b0, 1'b0, 13'h0009, 8'h00},
    '{1'b1, 1'b0, 13'h100C, 8'hFF},
    '{1'b0, 1'b0, 13'h100C, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ce_term = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [12:0] mem_addr;

  int tests = 0;
  int fails = 0;

  always #4 clk = !clk;

  sram_cycle_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ce_term(req_ce_term), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // behavioural memory: a byte lands only when the CE/WE overlap closes
  logic [7:0] mdl [16];
  logic wr_open;
  initial for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
  assign wr_open = !(mem_ce_n === 1'b0 && mem_we_n === 1'b0);
  always @(posedge wr_open) if (mem_dq_oe === 1'b1) mdl[mem_addr[3:0]] <= mem_dq_o;
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mdl[mem_addr[3:0]] : 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // issue one access and record the strobe trace until the response
  task automatic run_access(input vec_t v);
    int n = 0, ov = 0, rdc = 0, oebad = 0, drvbad = 0, addrbad = 0, dqbad = 0;
    logic ce0 = 1'b1, we0 = 1'b1, ce_after = 1'b1, we_after = 1'b1;
    logic in_ov = 1'b0, seen_end = 1'b0;
    @(negedge clk);
    chk("R11 ready before request", req_ready, 1'b1);
    req_valid = 1'b1; req_write = v.wr; req_ce_term = v.ce_term;
    req_addr = v.addr; req_wdata = v.data;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (rsp_valid) break;
      if (k == 0) begin ce0 = mem_ce_n; we0 = mem_we_n; end
      if (!mem_ce_n && !mem_we_n) begin
        ov++; in_ov = 1'b1;
        if (!mem_dq_oe || mem_dq_o !== v.data) dqbad++;
      end else if (in_ov && !seen_end) begin
        seen_end = 1'b1; ce_after = mem_ce_n; we_after = mem_we_n;
        if (!mem_dq_oe) dqbad++;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rdc++;
      if (!mem_we_n && !mem_oe_n) oebad++;
      if (!mem_oe_n && mem_dq_oe) drvbad++;
      if (mem_addr !== v.addr) addrbad++;
      n++;
      @(negedge clk);
    end
    chk("R11 ready at response", req_ready, 1'b1);
    chk("R8 address held", addrbad, 0);
    chk("R6 oe high in write", oebad, 0);
    if (v.wr) begin
      chk("R9 write length", n, v.ce_term ? LEN_WCE : LEN_WWE);
      chk(v.ce_term ? "R5 overlap length" : "R4 overlap length", ov, TB_WP);
      chk("R7 data driven through write", dqbad, 0);
      if (v.ce_term) begin
        chk("R5 first cycle ce/we", {ce0, we0}, 2'b10);
        chk("R5 ce rises first", {ce_after, we_after}, 2'b10);
      end else begin
        chk("R4 first cycle ce/we", {ce0, we0}, 2'b01);
        chk("R4 we rises first", {ce_after, we_after}, 2'b01);
      end
    end else begin
      chk("R2 read strobe cycles", rdc, TB_RD);
      chk("R9 read length", n, TB_RD);
      chk("R7 no drive in read", drvbad, 0);
      chk("R3 read data", rsp_rdata, v.data);
    end
    @(negedge clk);
    chk("R3 response one cycle", rsp_valid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state after reset
    chk("R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk("R1 no drive", mem_dq_oe, 1'b0);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 no response", rsp_valid, 1'b0);

    for (int i = 0; i < NV; i++) run_access(VECS[i]);

    // R10: request offered in the middle of a write is not taken
    begin
      int extra = 0, strobe = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_ce_term = 1'b0;
      req_addr = 13'h0005; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 not ready while busy", req_ready, 1'b0);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h0009;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (rsp_valid) extra++;
        if (!mem_ce_n || !mem_we_n || !mem_oe_n) strobe++;
      end
      chk("R10 no extra response", extra, 0);
      chk("R10 no extra cycle", strobe, 0);
      chk("R1 idle after access", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      run_access('{1'b0, 1'b0, 13'h0005, 8'h77});
    end

    summary();
    $finish;
  end

endmodule